// File: doc/BRIEF.md
# SPI Host Controller with Register Port

A single-lane SPI host controller driven by software through a small 32-bit register port. Software loads a word into the transmit queue and writes the command register with the frame length, SPI mode, target chip select and the transmit and receive enables. Setting the start bit together with the host-mode bit then runs one frame of 1 to 32 bits. The frame is shifted out on MOSI most significant bit first. The bits sampled on MISO are collected right-aligned and pushed into the receive queue, and a ready flag is raised when the frame ends.

Chip select can be driven by hardware, low for the length of each frame, or held at a level chosen by software across any number of frames. Both queues can be flushed from software, and each flush bit clears itself. Overflow and underrun events on either queue set sticky flags, along with an error summary. The sticky flags, like the ready flag, are cleared by writing 1 to them. SCLK is the system clock divided by twice a fixed parameter.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, the command register at byte offset 0x00 and the transfer status register at 0x04 read 0. The queue status register at 0x08 reads 0x0000_0005, meaning both queues are empty. All four chip-select outputs are high and SCLK is low.
- R2: Command bits 4:0 hold the frame length minus one. A frame shifts exactly length bits, taken from bits [length-1:0] of the transmit word, and sends the most significant of these first.
- R3: Command bits 29:28 hold {CPOL, CPHA}. SCLK idles at CPOL. Data is sampled on the leading SCLK edge when CPHA is 0 and on the trailing edge when CPHA is 1. The outgoing bit changes only on the edges that are not sampling edges.
- R4: When receive enable (command bit 12) is set, the bits sampled on MISO are pushed at the end of the frame as one word, right-aligned, with the last bit at bit 0. When it is clear, nothing is pushed. Reading offset 0x10 pops the receive queue.
- R5: When transmit enable (command bit 11) is set, starting a frame pops one word from the transmit queue, which is written at offset 0x0C. When it is clear, the transmit queue is left untouched and MOSI stays at 0 for the whole frame.
- R6: Command bits 27:26 select which of the four active-low chip selects is used. When bit 21 is set, the selected chip select follows command bit 20, where 0 drives it low. When bit 21 is clear, the selected chip select is low only while a frame runs. Chip selects that are not selected stay high.
- R7: Writing the command register with bit 31 and bit 30 both set starts a frame. Bit 31 then reads 1 until the frame ends and reads 0 afterwards. A start request with bit 30 clear does nothing. While a frame runs, writes to the command register change only bit 20.
- R8: Transfer status bit 30 is set when a frame completes. Writing 1 to it clears it.
- R9: Writing 1 to queue status bit 15 flushes the receive queue, and writing 1 to bit 14 flushes the transmit queue. Each bit reads back as 1 for one cycle and then reads 0, and the flushed queue is then empty.
- R10: A write to a full transmit queue is dropped and sets bit 7. Starting a frame with transmit enabled and the transmit queue empty sets bit 6 and sends zeros. Either event also sets the error summary, bit 8. Writing 1 to bits 8 to 4 clears them.
- R11: A frame ending with a full receive queue drops its word and sets bit 5. Reading an empty receive queue returns 0 and sets bit 4. Either event also sets bit 8.
- R12: Queue status bits 3, 2, 1 and 0 show transmit full, transmit empty, receive full and receive empty. Each queue holds FIFO_DEPTH words, 8 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read strobe |
| sclk_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |
| cs_no | output | 4 | Active-low chip selects |

## Verification
The bench builds the block with FIFO_DEPTH set to 4 and HALF_DIV set to 2. The shallow queues make full, overflow and underrun reachable in a handful of frames. The short divider keeps a 32-bit frame near 130 cycles, so every SPI mode can be run at lengths of 1, 8, 16, 24 and 32 bits. MISO is looped back inverted from MOSI, and the bench captures MOSI on its own idea of each mode's sampling edge. A wrong edge choice, a wrong bit order or a bad bit count therefore shows up both in the captured word and in the received word.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 5;
  localparam int CSS_W  = 2;
  localparam int NUM_CS = 1 << CSS_W;

  // word index taken from addr_i[4:2]
  localparam logic [2:0] IDX_CMD  = 3'd0;
  localparam logic [2:0] IDX_XSTS = 3'd1;
  localparam logic [2:0] IDX_QSTS = 3'd2;
  localparam logic [2:0] IDX_TXQ  = 3'd3;
  localparam logic [2:0] IDX_RXQ  = 3'd4;

  typedef struct packed {
    logic             host;
    logic [1:0]       mode;
    logic [CSS_W-1:0] sel;
    logic             cs_sw;
    logic             cs_lvl;
    logic             rx_en;
    logic             tx_en;
    logic [LEN_W-1:0] len;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} eng_st_e;
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  assert_no_push_full_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_pop_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_cnt_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              tx_en_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int EDGE_W = LEN_W + 1;

  eng_st_e            st_q;
  logic [DIV_W-1:0]   div_q;
  logic [EDGE_W-1:0]  edge_q;
  logic [LEN_W-1:0]   idx_q, len_q;
  logic [DATA_W-1:0]  sh_q, rx_q;
  logic               sclk_q, cpol_q, cpha_q;
  logic               tick, sample_ev, shift_ev;
  logic [EDGE_W-1:0]  last_edge;

  assign tick      = (div_q == DIV_W'(HALF_DIV - 1));
  assign last_edge = {len_q, 1'b1};
  // even edge index = leading edge
  assign sample_ev = (edge_q[0] == cpha_q);
  assign shift_ev  = cpha_q ? (!edge_q[0] && (edge_q != '0))
                            : (edge_q[0] && (edge_q != last_edge));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      div_q  <= '0;
      edge_q <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_SHIFT;
          div_q  <= '0;
          edge_q <= '0;
          idx_q  <= len_i;
          len_q  <= len_i;
          sh_q   <= tx_en_i ? tx_word_i : '0;
          rx_q   <= '0;
          sclk_q <= cpol_i;
          cpol_q <= cpol_i;
          cpha_q <= cpha_i;
        end
        ST_SHIFT: begin
          if (tick) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
            if (sample_ev) rx_q <= {rx_q[DATA_W-2:0], miso_i};
            if (shift_ev)  idx_q <= idx_q - 1'b1;
            if (edge_q == last_edge) st_q <= ST_DONE;
            else edge_q <= edge_q + 1'b1;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_DONE);
  assign rx_word_o = rx_q;
  assign sclk_o    = busy_o ? sclk_q : cpol_i;
  assign mosi_o    = busy_o ? sh_q[idx_q] : 1'b0;

  assert_sclk_home_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE) |-> (sclk_q == cpol_q));
  assert_mosi_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_SHIFT) && $past(st_q == ST_SHIFT) && $past(tick && sample_ev)) |-> $stable(mosi_o));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int HALF_DIV   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [4:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_no
);
  cmd_t              cmd_q;
  logic              start_q, ready_q;
  logic              rx_fl_q, tx_fl_q;
  logic              err_q, txo_q, txu_q, rxo_q, rxu_q;
  logic              eng_busy, eng_done, busy;
  logic [DATA_W-1:0] eng_rx, tx_head, rx_head;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_push, tx_pop, rx_push, rx_pop;
  logic              wr_cmd, wr_xsts, wr_qsts, wr_txq, rd_rxq;
  logic              ev_txo, ev_txu, ev_rxo, ev_rxu;
  logic [2:0]        idx;
  logic              unused_addr;

  assign idx         = addr_i[4:2];
  assign unused_addr = ^addr_i[1:0];
  assign wr_cmd  = req_i && we_i && (idx == IDX_CMD);
  assign wr_xsts = req_i && we_i && (idx == IDX_XSTS);
  assign wr_qsts = req_i && we_i && (idx == IDX_QSTS);
  assign wr_txq  = req_i && we_i && (idx == IDX_TXQ);
  assign rd_rxq  = req_i && !we_i && (idx == IDX_RXQ);

  assign busy = start_q || eng_busy;

  // command register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (wr_cmd) begin
        if (busy) begin
          cmd_q.cs_lvl <= wdata_i[20];
        end else begin
          cmd_q.host   <= wdata_i[30];
          cmd_q.mode   <= wdata_i[29:28];
          cmd_q.sel    <= wdata_i[27:26];
          cmd_q.cs_sw  <= wdata_i[21];
          cmd_q.cs_lvl <= wdata_i[20];
          cmd_q.rx_en  <= wdata_i[12];
          cmd_q.tx_en  <= wdata_i[11];
          cmd_q.len    <= wdata_i[4:0];
          start_q      <= wdata_i[31] && wdata_i[30];
        end
      end
    end
  end

  // queues and events
  assign tx_push = wr_txq && !tx_full;
  assign ev_txo  = wr_txq && tx_full;
  assign tx_pop  = start_q && cmd_q.tx_en && !tx_empty;
  assign ev_txu  = start_q && cmd_q.tx_en && tx_empty;
  assign rx_push = eng_done && cmd_q.rx_en && !rx_full;
  assign ev_rxo  = eng_done && cmd_q.rx_en && rx_full;
  assign rx_pop  = rd_rxq && !rx_empty;
  assign ev_rxu  = rd_rxq && rx_empty;

  spi_host_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni, .flush_i(tx_fl_q), .push_i(tx_push), .wdata_i(wdata_i),
    .pop_i(tx_pop), .rdata_o(tx_head), .full_o(tx_full), .empty_o(tx_empty)
  );

  spi_host_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk_i, .rst_ni, .flush_i(rx_fl_q), .push_i(rx_push), .wdata_i(eng_rx),
    .pop_i(rx_pop), .rdata_o(rx_head), .full_o(rx_full), .empty_o(rx_empty)
  );

  spi_host_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk_i, .rst_ni,
    .start_i(start_q), .cpol_i(cmd_q.mode[1]), .cpha_i(cmd_q.mode[0]),
    .len_i(cmd_q.len), .tx_en_i(cmd_q.tx_en && !tx_empty), .tx_word_i(tx_head),
    .miso_i, .busy_o(eng_busy), .done_o(eng_done), .rx_word_o(eng_rx),
    .sclk_o, .mosi_o
  );

  // status: set wins over write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      rx_fl_q <= 1'b0;
      tx_fl_q <= 1'b0;
      err_q   <= 1'b0;
      txo_q   <= 1'b0;
      txu_q   <= 1'b0;
      rxo_q   <= 1'b0;
      rxu_q   <= 1'b0;
    end else begin
      ready_q <= eng_done || (ready_q && !(wr_xsts && wdata_i[30]));
      rx_fl_q <= wr_qsts && wdata_i[15];
      tx_fl_q <= wr_qsts && wdata_i[14];
      err_q   <= ev_txo || ev_txu || ev_rxo || ev_rxu || (err_q && !(wr_qsts && wdata_i[8]));
      txo_q   <= ev_txo || (txo_q && !(wr_qsts && wdata_i[7]));
      txu_q   <= ev_txu || (txu_q && !(wr_qsts && wdata_i[6]));
      rxo_q   <= ev_rxo || (rxo_q && !(wr_qsts && wdata_i[5]));
      rxu_q   <= ev_rxu || (rxu_q && !(wr_qsts && wdata_i[4]));
    end
  end

  // chip selects
  always_comb begin
    cs_no = '1;
    cs_no[cmd_q.sel] = cmd_q.cs_sw ? cmd_q.cs_lvl : !eng_busy;
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    case (idx)
      IDX_CMD: begin
        rdata_o[31]    = busy;
        rdata_o[30]    = cmd_q.host;
        rdata_o[29:28] = cmd_q.mode;
        rdata_o[27:26] = cmd_q.sel;
        rdata_o[21]    = cmd_q.cs_sw;
        rdata_o[20]    = cmd_q.cs_lvl;
        rdata_o[12]    = cmd_q.rx_en;
        rdata_o[11]    = cmd_q.tx_en;
        rdata_o[4:0]   = cmd_q.len;
      end
      IDX_XSTS: rdata_o[30] = ready_q;
      IDX_QSTS: rdata_o[15:0] = {rx_fl_q, tx_fl_q, 5'b0, err_q, txo_q, txu_q,
                                 rxo_q, rxu_q, tx_full, tx_empty, rx_full, rx_empty};
      IDX_RXQ:  rdata_o = rx_empty ? '0 : rx_head;
      default:  rdata_o = '0;
    endcase
  end

  assert_ready_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done |=> ready_q);
  assert_cmd_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_busy && $past(eng_busy)) |-> ($stable(cmd_q.len) && $stable(cmd_q.mode) && $stable(cmd_q.sel)));
  assert_one_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1);
  assert_rx_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fl_q |=> rx_empty);
  assert_unr_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && cmd_q.tx_en && tx_empty) |=> (err_q && txu_q));
endmodule

// File: tb/spi_host_ctrl_tb.sv
module spi_host_ctrl_tb_top;
  localparam int DEPTH = 4;
  localparam logic [4:0] A_CMD = 5'h00, A_XS = 5'h04, A_QS = 5'h08, A_TX = 5'h0C, A_RX = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  cs_n;

  int checks = 0, fails = 0;
  logic        cap_on = 1'b0;
  logic [1:0]  cur_mode = '0, cur_sel = '0;
  logic [31:0] cap_word = '0;
  int          cap_n = 0;

  always #4 clk = ~clk;
  assign miso = ~mosi;

  spi_host_ctrl #(.FIFO_DEPTH(DEPTH), .HALF_DIV(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  always @(posedge sclk)
    if (cap_on && !cs_n[cur_sel] && (cur_mode == 2'd0 || cur_mode == 2'd3)) begin
      cap_word = {cap_word[30:0], mosi};
      cap_n++;
    end
  always @(negedge sclk)
    if (cap_on && !cs_n[cur_sel] && (cur_mode == 2'd1 || cur_mode == 2'd2)) begin
      cap_word = {cap_word[30:0], mosi};
      cap_n++;
    end

  localparam logic [1:0]  V_MODE [6] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd3};
  localparam logic [1:0]  V_SEL  [6] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd0};
  localparam logic [4:0]  V_LEN  [6] = '{5'd7, 5'd15, 5'd31, 5'd0, 5'd23, 5'd31};
  localparam logic [31:0] V_TX   [6] = '{32'h0000_00A5, 32'hDEAD_BEEF, 32'h8000_0001,
                                         32'h0000_0001, 32'h005A_C396, 32'h7FFF_FFFE};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #2 d = rdata;
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  function automatic logic [31:0] mk_cmd(input logic go, input logic host, input logic [1:0] mode,
                                         input logic [1:0] sel, input logic sw, input logic lvl,
                                         input logic rxen, input logic txen, input logic [4:0] len);
    logic [31:0] c = '0;
    c[31] = go; c[30] = host; c[29:28] = mode; c[27:26] = sel;
    c[21] = sw; c[20] = lvl; c[12] = rxen; c[11] = txen; c[4:0] = len;
    return c;
  endfunction

  function automatic logic [31:0] mask_of(input logic [4:0] len);
    logic [32:0] m = (33'h1 << (int'(len) + 1)) - 33'h1;
    return m[31:0];
  endfunction

  task automatic wait_ready();
    logic [31:0] d;
    for (int i = 0; i < 400; i++) begin
      bus_rd(A_XS, d);
      if (d[30]) break;
    end
  endtask

  task automatic run_frame(input logic [1:0] mode, input logic [1:0] sel, input logic [4:0] len,
                           input logic rxen, input logic txen);
    bus_wr(A_CMD, mk_cmd(1'b0, 1'b1, mode, sel, 1'b0, 1'b0, rxen, txen, len));
    cur_mode = mode; cur_sel = sel; cap_word = '0; cap_n = 0; cap_on = 1'b1;
    bus_wr(A_CMD, mk_cmd(1'b1, 1'b1, mode, sel, 1'b0, 1'b0, rxen, txen, len));
    wait_ready();
    cap_on = 1'b0;
    bus_wr(A_XS, 32'h4000_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, c0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    bus_rd(A_CMD, d); chk("R1 cmd", d, 32'h0);
    bus_rd(A_XS, d);  chk("R1 xsts", d, 32'h0);
    bus_rd(A_QS, d);  chk("R1 qsts", d, 32'h5);
    chk("R1 cs", {28'h0, cs_n}, 32'hF);
    chk("R1 sclk", {31'h0, sclk}, 32'h0);

    // table walk: R2 R3 R4 R8
    for (int v = 0; v < 6; v++) begin
      bus_wr(A_TX, V_TX[v]);
      bus_wr(A_CMD, mk_cmd(1'b0, 1'b1, V_MODE[v], V_SEL[v], 1'b0, 1'b0, 1'b1, 1'b1, V_LEN[v]));
      #1 chk("R3 sclk idle", {31'h0, sclk}, {31'h0, V_MODE[v][1]});
      run_frame(V_MODE[v], V_SEL[v], V_LEN[v], 1'b1, 1'b1);
      chk("R2 bit count", cap_n, int'(V_LEN[v]) + 1);
      chk("R2 R3 mosi word", cap_word, V_TX[v] & mask_of(V_LEN[v]));
      bus_rd(A_RX, d);
      chk("R4 rx word", d, ~V_TX[v] & mask_of(V_LEN[v]));
      bus_rd(A_XS, d);
      chk("R8 ready cleared", d, 32'h0);
      chk("R6 cs released", {28'h0, cs_n}, 32'hF);
    end

    // R8 ready set and held until cleared
    bus_wr(A_TX, 32'h3C);
    bus_wr(A_CMD, mk_cmd(1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd7));
    wait_ready();
    bus_rd(A_XS, d); chk("R8 ready held", d, 32'h4000_0000);
    bus_wr(A_XS, 32'h4000_0000);
    bus_rd(A_XS, d); chk("R8 ready w1c", d, 32'h0);

    // R7 writes while busy change only bit 20
    bus_wr(A_TX, 32'hFFFF_0000);
    c0 = mk_cmd(1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd31);
    bus_wr(A_CMD, c0);
    cur_mode = 2'd0; cur_sel = 2'd0; cap_word = '0; cap_n = 0; cap_on = 1'b1;
    bus_wr(A_CMD, c0 | 32'h8000_0000);
    bus_rd(A_CMD, d); chk("R7 go reads 1", d, c0 | 32'h8000_0000);
    bus_wr(A_CMD, mk_cmd(1'b1, 1'b1, 2'd3, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 5'd5));
    bus_rd(A_CMD, d); chk("R7 busy write ignored", d, c0 | 32'h8010_0000);
    wait_ready();
    cap_on = 1'b0;
    bus_wr(A_XS, 32'h4000_0000);
    bus_rd(A_CMD, d); chk("R7 go self clear", d, c0 | 32'h0010_0000);
    chk("R7 length kept", cap_n, 32);
    chk("R2 upper half", cap_word, 32'hFFFF_0000);

    // R7 no start without host bit
    bus_wr(A_CMD, 32'h8000_0807);
    repeat (80) @(posedge clk);
    bus_rd(A_XS, d);  chk("R7 no host no frame", d, 32'h0);
    bus_rd(A_CMD, d); chk("R7 no host go", d, 32'h0000_0807);

    // R6 software chip select
    bus_wr(A_CMD, mk_cmd(1'b0, 1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd7));
    #1 chk("R6 sw low", {28'h0, cs_n}, 32'hB);
    bus_wr(A_CMD, mk_cmd(1'b0, 1'b1, 2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 5'd7));
    #1 chk("R6 sw high", {28'h0, cs_n}, 32'hF);
    bus_wr(A_CMD, mk_cmd(1'b0, 1'b1, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 5'd7));

    // R4 receive disabled
    run_frame(2'd1, 2'd0, 5'd7, 1'b0, 1'b0);
    bus_rd(A_QS, d); chk("R4 no push", d, 32'h5);

    // R5 transmit disabled keeps queue, sends zeros
    bus_wr(A_TX, 32'hFFFF_FFFF);
    run_frame(2'd0, 2'd0, 5'd7, 1'b0, 1'b0);
    chk("R5 mosi zero", cap_word, 32'h0);
    bus_rd(A_QS, d); chk("R5 tx kept", d, 32'h1);

    // R9 transmit flush
    bus_wr(A_QS, 32'h4000);
    bus_rd(A_QS, d); chk("R9 tx flush busy", d, 32'h4001);
    bus_rd(A_QS, d); chk("R9 tx flush done", d, 32'h5);

    // R9 receive flush
    run_frame(2'd0, 2'd0, 5'd3, 1'b1, 1'b0);
    bus_rd(A_QS, d); chk("R12 rx nonempty", d, 32'h4);
    bus_wr(A_QS, 32'h8000);
    bus_rd(A_QS, d); chk("R9 rx flush busy", d, 32'h8004);
    bus_rd(A_QS, d); chk("R9 rx flush done", d, 32'h5);

    // R10 underrun
    run_frame(2'd0, 2'd0, 5'd7, 1'b0, 1'b1);
    chk("R10 underrun zeros", cap_word, 32'h0);
    bus_rd(A_QS, d); chk("R10 underrun flags", d, 32'h145);
    bus_wr(A_QS, 32'h1F0);
    bus_rd(A_QS, d); chk("R10 w1c", d, 32'h5);

    // R10 R12 transmit overflow
    for (int i = 0; i <= DEPTH; i++) bus_wr(A_TX, 32'(i));
    bus_rd(A_QS, d); chk("R10 tx overflow", d, 32'h189);
    bus_wr(A_QS, 32'h4180);
    bus_rd(A_QS, d); chk("R9 flush with clear", d, 32'h4009);
    bus_rd(A_QS, d); chk("R12 tx empty again", d, 32'h5);

    // R11 R12 receive overflow and underrun
    for (int i = 0; i <= DEPTH; i++) run_frame(2'd2, 2'd1, 5'd3, 1'b1, 1'b0);
    bus_rd(A_QS, d); chk("R11 rx overflow", d, 32'h126);
    for (int i = 0; i < DEPTH; i++) begin
      bus_rd(A_RX, d); chk("R11 rx kept word", d, 32'hF);
    end
    bus_rd(A_RX, d); chk("R11 underrun data", d, 32'h0);
    bus_rd(A_QS, d); chk("R11 underrun flags", d, 32'h135);
    bus_wr(A_QS, 32'h130);
    bus_rd(A_QS, d); chk("R11 w1c", d, 32'h5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule